// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation period of up to three cooling fans. Each channel counts ticks of a divided reference clock between two rising edges of the fan's tachometer pulse. The count therefore rises as the fan slows down. The count stops at full scale (255) and does not wrap, so a fan that has stopped or is turning very slowly reads 255. With the prescale chosen for a fan's rated speed, a healthy fan reads about 153.

Each tach input passes through a synchronizer and a glitch filter before edge detection. At every measured rising edge, the count is latched into an 8-bit result that a register port can read, and it is compared with a per-channel high limit. A count above the limit sets a sticky alarm bit, which stays set until the channel's read strobe clears it.

The first two channels take their prescale code from a shared 4-bit divisor field. The third channel always counts with a fixed prescale of 2.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every result reads 0 and every alarm bit reads 0.
- R2: The time between two filtered rising tach edges is P clock cycles. The tick length is T = BASE_DIV × prescale clock cycles. The latched result is min(255, floor((P−1)/T)).
- R3: Channel 0 takes its prescale code from div_field_i[1:0] and channel 1 from div_field_i[3:2]. The codes 00, 01, 10 and 11 select prescale 1, 2, 4 and 8.
- R4: Channel 2 always uses prescale 2, whatever the value of div_field_i.
- R5: The counter saturates at 255 and never wraps. The result shows 255 as soon as the counter reaches 255, even when no further tach edge arrives.
- R6: A tach pulse one clock cycle wide is rejected and does not change the measured period. Edge detection uses a 2-of-3 majority vote over synchronized samples.
- R7: An alarm is set when a latched value is strictly greater than the channel's limit. A value equal to the limit does not set it.
- R8: An alarm bit stays set until the channel's rd_i strobe is high for a cycle. If no new value above the limit is latched in that cycle, the bit then clears.
- R9: A result changes only at a latch event, which is a rising tach edge or the counter reaching full scale. Between latch events it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_i | input | NCH | Raw tachometer inputs, one bit per channel |
| div_field_i | input | 4 | Divisor field: [1:0] for channel 0, [3:2] for channel 1 |
| limit_i | input | NCH*CW | High limit for each channel, packed by channel |
| rd_i | input | NCH | Read strobe for each channel; clears that channel's alarm |
| count_o | output | NCH*CW | Latched period count for each channel, packed by channel |
| alarm_o | output | NCH | Sticky over-limit alarm for each channel |

## Verification
A prescaler that is not restarted at the edge, or a miscounted tick length, shows up as a result that is off by one or more. The error appears at the first complete period after the stimulus settles, so sweeping periods placed right at the floor boundaries exposes it within one or two tach periods. A counter that wraps instead of saturating shows up as a small value when the fan is stalled. A result that fails to update without an edge leaves the stalled-fan reading stuck at its old value once 255 ticks have passed. A wrong priority between alarm set and clear, or a comparison that includes the equal case, changes alarm_o within a cycle of the latch or the read strobe.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  typedef logic [1:0] div_code_t;

  // prescale factor selected by a 2-bit divisor code
  function automatic int unsigned prescale_of(div_code_t code);
    return 32'd1 << code;
  endfunction

  // 2-of-3 vote
  function automatic logic vote3(logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/fan_tach_filter.sv
module fan_tach_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  import fan_tach_pkg::*;

  logic       meta_q, sync_q;
  logic [2:0] hist_q;
  logic       level_q;
  logic       voted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      hist_q  <= '0;
      level_q <= 1'b0;
    end else begin
      meta_q  <= raw_i;
      sync_q  <= meta_q;
      hist_q  <= {hist_q[1:0], sync_q};
      level_q <= voted;
    end
  end

  assign voted  = vote3(hist_q);
  assign rise_o = voted & ~level_q;

endmodule

// File: rtl/fan_tach_chan.sv
module fan_tach_chan #(
  parameter int CW       = 8,
  parameter int BASE_DIV = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rise_i,
  input  fan_tach_pkg::div_code_t   code_i,
  input  logic [CW-1:0]             limit_i,
  input  logic                      rd_i,
  output logic [CW-1:0]             result_o,
  output logic                      alarm_o,
  output logic                      latch_o,
  output logic [CW-1:0]             cnt_o
);
  import fan_tach_pkg::*;

  localparam int unsigned SPAN_MAX = BASE_DIV * 8;
  localparam int          PW       = $clog2(SPAN_MAX + 1);
  localparam logic [CW-1:0] FULL   = '1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] span;
  logic [CW-1:0] cnt_q;
  logic          tick;
  logic          full;
  logic          sat_evt;
  logic [CW-1:0] latch_val;
  logic          over;

  assign span      = PW'(BASE_DIV * prescale_of(code_i));
  assign tick      = (pre_q == span - PW'(1));
  assign full      = (cnt_q == FULL);
  assign sat_evt   = tick & ~rise_i & (cnt_q == FULL - CW'(1));
  assign latch_o   = rise_i | sat_evt;
  assign latch_val = rise_i ? cnt_q : FULL;
  assign over      = latch_o & (latch_val > limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (rise_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      if (!full) cnt_q <= cnt_q + CW'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      alarm_o  <= 1'b0;
    end else begin
      if (latch_o) result_o <= latch_val;
      alarm_o <= (alarm_o & ~rd_i) | over;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
  parameter int NCH        = 3,
  parameter int CW         = 8,
  parameter int BASE_DIV   = 4,
  parameter int PROG_CH    = 2,
  parameter logic [1:0] FIXED_CODE = 2'b01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      tach_i,
  input  logic [2*PROG_CH-1:0] div_field_i,
  input  logic [NCH*CW-1:0]   limit_i,
  input  logic [NCH-1:0]      rd_i,
  output logic [NCH*CW-1:0]   count_o,
  output logic [NCH-1:0]      alarm_o
);
  import fan_tach_pkg::*;

  logic [NCH-1:0]    rise_w;
  logic [NCH-1:0]    latch_w;
  logic [NCH*CW-1:0] cnt_w;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    div_code_t code;

    if (k < PROG_CH) begin : g_prog
      assign code = div_field_i[2*k +: 2];
    end else begin : g_fixed
      assign code = FIXED_CODE;
    end

    fan_tach_filter u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (tach_i[k]),
      .rise_o (rise_w[k])
    );

    fan_tach_chan #(.CW(CW), .BASE_DIV(BASE_DIV)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise_w[k]),
      .code_i   (code),
      .limit_i  (limit_i[k*CW +: CW]),
      .rd_i     (rd_i[k]),
      .result_o (count_o[k*CW +: CW]),
      .alarm_o  (alarm_o[k]),
      .latch_o  (latch_w[k]),
      .cnt_o    (cnt_w[k*CW +: CW])
    );
  end

endmodule

// File: rtl/fan_tach_chk.sv
module fan_tach_chk #(
  parameter int NCH = 3,
  parameter int CW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    rise_w,
  input logic [NCH-1:0]    latch_w,
  input logic [NCH*CW-1:0] cnt_w,
  input logic [NCH*CW-1:0] count_o,
  input logic [NCH*CW-1:0] limit_i,
  input logic [NCH-1:0]    rd_i,
  input logic [NCH-1:0]    alarm_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_a
    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_w[k*CW +: CW] == {CW{1'b1}}) && !rise_w[k] |=> (cnt_w[k*CW +: CW] == {CW{1'b1}}));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_w[k] |=> (cnt_w[k*CW +: CW] == $past(cnt_w[k*CW +: CW]))
                  || (cnt_w[k*CW +: CW] == $past(cnt_w[k*CW +: CW]) + CW'(1)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_w[k] |=> $stable(count_o[k*CW +: CW]));

    // R7
    alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_w[k] |=> (!(count_o[k*CW +: CW] > $past(limit_i[k*CW +: CW])) || alarm_o[k]));

    // R8
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o[k] && !rd_i[k] |=> alarm_o[k]);

    // R6
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_w[k] |=> !rise_w[k]);
  end
endmodule

bind fan_tach_monitor fan_tach_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rise_w  (rise_w),
  .latch_w (latch_w),
  .cnt_w   (cnt_w),
  .count_o (count_o),
  .limit_i (limit_i),
  .rd_i    (rd_i),
  .alarm_o (alarm_o)
);

// File: tb/fan_tach_monitor_bench.sv
module fan_tach_monitor_bench;
  localparam int NCH  = 3;
  localparam int CW   = 8;
  localparam int BASE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tach_b [NCH];
  logic [NCH-1:0]    tach;
  logic [3:0]        div_field = '0;
  logic [NCH*CW-1:0] limit;
  logic [NCH-1:0]    rd = '0;
  logic [NCH*CW-1:0] count;
  logic [NCH-1:0]    alarm;

  int per    [NCH];
  bit glitch [NCH];
  int lim    [NCH];
  int cur_p  [NCH];
  int cur_t  [NCH];
  bit prev_over [NCH];
  int prev_max;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign tach = {tach_b[2], tach_b[1], tach_b[0]};

  fan_tach_monitor u_fan_tach_monitor (
    .clk(clk), .rst_n(rst_n), .tach_i(tach), .div_field_i(div_field),
    .limit_i(limit), .rd_i(rd), .count_o(count), .alarm_o(alarm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gen(input int ch);
    forever begin
      int p;
      p = per[ch];
      if (p == 0) begin
        tach_b[ch] = 1'b0;
        @(negedge clk);
      end else begin
        tach_b[ch] = 1'b1;
        repeat (p / 2) @(negedge clk);
        tach_b[ch] = 1'b0;
        if (glitch[ch] && (p - p / 2) >= 6) begin
          repeat (2) @(negedge clk);
          tach_b[ch] = 1'b1;
          @(negedge clk);
          tach_b[ch] = 1'b0;
          repeat (p - p / 2 - 3) @(negedge clk);
        end else begin
          repeat (p - p / 2) @(negedge clk);
        end
      end
    end
  endtask

  function automatic int tick_of(int ch, int code);
    // R3 prescale 1,2,4,8 for codes 0..3; R4 channel 2 fixed at 2
    if (ch < 2) return BASE * (1 << code);
    return BASE * 2;
  endfunction

  function automatic int expect_cnt(int p, int t);
    int q;
    if (p == 0) return 255;
    q = (p - 1) / t;
    return (q > 255) ? 255 : q;
  endfunction

  task automatic check_results(input string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      int e, a;
      e = expect_cnt(cur_p[ch], cur_t[ch]);
      a = int'(count[ch*CW +: CW]);
      chk(a == e, tag, a, e);
    end
    repeat (5) @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      int e, a;
      e = expect_cnt(cur_p[ch], cur_t[ch]);
      a = int'(count[ch*CW +: CW]);
      chk(a == e, "R9 hold", a, e);
    end
    // R7 / R8 alarm expectations
    for (int ch = 0; ch < NCH; ch++) begin
      bit over;
      over = expect_cnt(cur_p[ch], cur_t[ch]) > lim[ch];
      chk(alarm[ch] == (over | prev_over[ch]), "R7 alarm", int'(alarm[ch]),
          int'(over | prev_over[ch]));
      if (!over) rd[ch] = 1'b1;
      prev_over[ch] = over;
    end
    @(negedge clk);
    rd = '0;
    repeat (3) @(negedge clk);
    for (int ch = 0; ch < NCH; ch++)
      if (!prev_over[ch]) chk(alarm[ch] == 1'b0, "R8 clear", int'(alarm[ch]), 0);
  endtask

  task automatic run_step(input int code, input int n, input int offk, input bit gl,
                          input string tag);
    int mx;
    mx = 0;
    div_field = {code[1:0], code[1:0]};
    for (int ch = 0; ch < NCH; ch++) begin
      int t;
      t = tick_of(ch, code);
      cur_t[ch] = t;
      cur_p[ch] = t * n + ((offk == 0) ? 0 : (offk == 1) ? 1 : t - 1);
      per[ch] = cur_p[ch];
      glitch[ch] = gl;
      if (cur_p[ch] > mx) mx = cur_p[ch];
    end
    repeat (prev_max + 3 * mx + 40) @(negedge clk);
    prev_max = mx;
    check_results(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    lim[0] = 153; lim[1] = 152; lim[2] = 9;
    for (int ch = 0; ch < NCH; ch++) begin
      limit[ch*CW +: CW] = CW'(lim[ch]);
      per[ch] = 0; glitch[ch] = 0; tach_b[ch] = 1'b0; prev_over[ch] = 0;
    end
    prev_max = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      chk(count[ch*CW +: CW] == '0, "R1 count", int'(count[ch*CW +: CW]), 0);
      chk(alarm[ch] == 1'b0, "R1 alarm", int'(alarm[ch]), 0);
    end
    fork gen(0); gen(1); gen(2); join_none

    // R2 R3 R4 sweep over every code, periods on floor boundaries
    for (int code = 0; code < 4; code++) begin
      run_step(code, 10, 0, 0, "R2 below boundary");
      run_step(code, 10, 1, 0, "R3 on boundary");
      run_step(code, 153, 1, 0, "R4 nominal");
      run_step(code, 60, 2, 0, "R2 top of bin");
    end

    // R6 single-cycle glitch in the low phase must not shorten the period
    run_step(3, 20, 0, 1, "R6 glitch");
    for (int ch = 0; ch < NCH; ch++) glitch[ch] = 0;

    // R5 stalled fan and overlong periods read full scale
    per[0] = 0;      cur_p[0] = 0;           cur_t[0] = tick_of(0, 3);
    per[1] = 32*300; cur_p[1] = 32*300;      cur_t[1] = tick_of(1, 3);
    per[2] = 8*300;  cur_p[2] = 8*300;       cur_t[2] = tick_of(2, 3);
    repeat (prev_max + 3 * 9600 + 40) @(negedge clk);
    prev_max = 9600;
    check_results("R5 saturate");

    // R5 recovery after saturation: no residue from the full count
    run_step(3, 10, 1, 0, "R5 recover");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule